// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block takes one asynchronous serial line and turns each frame on it into a character for a receive FIFO. It runs on a reference clock qualified by a one-cycle sample tick, and it samples every bit at its centre after counting 8 or 16 ticks per bit. The word length (5 to 8 data bits), the parity mode (off, even, odd or fixed), the stop-bit count, the oversampling factor and an optional start-bit half-period are set by static configuration inputs. These inputs are captured when a start bit is detected, so a change made while a character is being received applies only to the next character.

Each completed character goes out as a one-cycle push strobe. The strobe comes with the data byte and with frame, parity and break flags that are valid in the same cycle. A held-low line gives exactly one all-zero break character, and reception stays disarmed until the line returns high. A character that completes while the FIFO reports full is dropped, and a sticky overrun level is raised that stays up until the FIFO has space again. Because the line is resynchronised, the first sample happens a fixed number of clocks after the falling edge.

Top module: `uart_frame_rx`

## Requirements
- R1: The word-length code `cfg_wlen` gives 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits arrive least significant first. Bits of `push_data` above the word length are 0.
- R2: `push` is high for exactly one cycle per accepted character. With tick always high, it rises H+4+N·K clocks after the line falls. H is the start half-period, N is the ticks per bit, and K is the count of data, parity and stop bits.
- R3: With `cfg_par_en`=1 and `cfg_stick`=0, `err_parity` is set when the number of ones across the data bits and the parity bit is odd while `cfg_par_even`=1, or even while `cfg_par_even`=0.
- R4: With `cfg_stick`=1 and parity enabled, the parity bit must be 0 when `cfg_par_even`=1 and 1 when `cfg_par_even`=0. Any other value sets `err_parity`.
- R5: `err_frame` is set when a sampled stop bit is 0. With `cfg_two_stop`=1, a second stop bit is sampled and checked, which adds one bit time to the frame.
- R6: When every sample of a frame is 0 (start, data, parity and stop), exactly one character is pushed. It has `push_data`=0 and `err_break`=1, with `err_frame` and `err_parity` both 0.
- R7: After a break, no new character is accepted until the line has been high. The next valid start bit after that is received normally.
- R8: A character that completes while `fifo_full`=1 is not pushed, and `err_overrun` rises in the next cycle. `err_overrun` falls in the first cycle after a cycle in which `fifo_full`=0.
- R9: `cfg_ovs8`=0 selects 16 ticks per bit and `cfg_ovs8`=1 selects 8 ticks per bit.
- R10: A non-zero `cfg_start_half` sets H to that value. Zero selects H = N/2−1.
- R11: Configuration changed after a start bit has been detected does not affect that character.
- R12: If the line is high again at the start-bit midpoint, nothing is pushed and the receiver returns to idle.
- R13: With `rx_en`=0, no start bit is detected and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle sample tick from the baud generator |
| rx_en | input | 1 | Permits detection of new start bits |
| rx_line | input | 1 | Serial line (idle high) |
| cfg_wlen | input | 2 | Word-length code, 0..3 maps to 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stick | input | 1 | Fixed (stick) parity check |
| cfg_two_stop | input | 1 | Check a second stop bit |
| cfg_ovs8 | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| cfg_start_half | input | 4 | Start midpoint tick count; 0 = default |
| fifo_full | input | 1 | Receive FIFO has no space |
| push | output | 1 | One-cycle write strobe to the FIFO |
| push_data | output | 8 | Received character |
| err_frame | output | 1 | Stop bit sampled low (valid with push) |
| err_parity | output | 1 | Parity mismatch (valid with push) |
| err_break | output | 1 | Break character (valid with push) |
| err_overrun | output | 1 | Character lost because the FIFO was full |

## Verification
Each result is due at a known cycle. The two synchroniser stages and the start-detect register place the start decision H+1 clocks after detection. Every later sample falls N clocks after the one before it, and the push strobe and its flags register one clock after the last stop sample. The bench drives each bit on falling edges for N clocks. It counts rising edges from the start-bit fall and samples one time unit after each edge, so it can compare the cycle in which `push` appears against H+4+N·K. The overrun level is checked on the cycle after the dropped character and again one cycle after `fifo_full` falls.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       stick;
        logic       two_stop;
        logic       ovs8;
        logic [3:0] start_half;
    } rx_cfg_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              par_even,
    input  logic              stick,
    output logic              par_err
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^data) ^ par_bit;
        if (stick) begin
            // fixed bit: 0 for even select, 1 for odd select
            par_err = (par_bit != !par_even);
        end else if (par_even) begin
            par_err = ones_odd;
        end else begin
            par_err = !ones_odd;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WLEN_BASE   = 5,
    parameter int OVS_HI      = 16,
    parameter int OVS_LO      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rx_en,
    input  logic              rx_line,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_stick,
    input  logic              cfg_two_stop,
    input  logic              cfg_ovs8,
    input  logic [3:0]        cfg_start_half,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_break,
    output logic              err_overrun
);
    localparam int CNT_W = $clog2(OVS_HI);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OVS_HI - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OVS_LO - 1);
    localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(OVS_HI / 2 - 1);
    localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(OVS_LO / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(WLEN_BASE - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par_bit;
        logic              stop_bad;
        logic              all_zero;
        rx_cfg_t           cfg;
        logic              push;
        logic [DATA_W-1:0] dout;
        logic              fe;
        logic              pe;
        logic              be;
        logic              ovr;
    } rx_regs_t;

    rx_regs_t rx_d, rx_q;

    logic             line_s;
    logic             par_err;
    rx_cfg_t          cfg_in;
    logic [CNT_W-1:0] bit_last;
    logic [CNT_W-1:0] half_lim;
    logic [IDX_W-1:0] idx_last;
    logic             do_finish;
    logic             stop_bad_n;
    logic             all_zero_n;

    uart_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    uart_rx_parity #(.DATA_W(DATA_W)) u_par (
        .data    (rx_q.shreg),
        .par_bit (rx_q.par_bit),
        .par_even(rx_q.cfg.par_even),
        .stick   (rx_q.cfg.stick),
        .par_err (par_err)
    );

    always_comb begin
        cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                   stick: cfg_stick, two_stop: cfg_two_stop, ovs8: cfg_ovs8,
                   start_half: cfg_start_half};
        bit_last = rx_q.cfg.ovs8 ? LAST_LO : LAST_HI;
        if (rx_q.cfg.start_half != 4'd0) half_lim = CNT_W'(rx_q.cfg.start_half);
        else                             half_lim = rx_q.cfg.ovs8 ? HALF_LO : HALF_HI;
        idx_last = IDX_BASE + IDX_W'(rx_q.cfg.wlen);
    end

    always_comb begin
        rx_d       = rx_q;
        rx_d.push  = 1'b0;
        do_finish  = 1'b0;
        stop_bad_n = rx_q.stop_bad;
        all_zero_n = rx_q.all_zero;
        if (rx_q.ovr && !fifo_full) rx_d.ovr = 1'b0;

        unique case (rx_q.st)
            RX_IDLE: begin
                if (tick_en && rx_en && !line_s) begin
                    rx_d.st  = RX_START;
                    rx_d.cnt = '0;
                    rx_d.cfg = cfg_in;
                end
            end
            RX_START: begin
                if (tick_en) begin
                    if (rx_q.cnt == half_lim) begin
                        rx_d.cnt = '0;
                        if (line_s) begin
                            rx_d.st = RX_IDLE;
                        end else begin
                            rx_d.st       = RX_DATA;
                            rx_d.idx      = '0;
                            rx_d.shreg    = '0;
                            rx_d.par_bit  = 1'b0;
                            rx_d.stop_bad = 1'b0;
                            rx_d.all_zero = 1'b1;
                        end
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick_en) begin
                    if (rx_q.cnt == bit_last) begin
                        rx_d.cnt               = '0;
                        rx_d.shreg[rx_q.idx]   = line_s;
                        rx_d.all_zero          = rx_q.all_zero & ~line_s;
                        if (rx_q.idx == idx_last) begin
                            rx_d.st = rx_q.cfg.par_en ? RX_PAR : RX_STOP1;
                        end else begin
                            rx_d.idx = rx_q.idx + 1'b1;
                        end
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (tick_en) begin
                    if (rx_q.cnt == bit_last) begin
                        rx_d.cnt      = '0;
                        rx_d.par_bit  = line_s;
                        rx_d.all_zero = rx_q.all_zero & ~line_s;
                        rx_d.st       = RX_STOP1;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP1, RX_STOP2: begin
                if (tick_en) begin
                    if (rx_q.cnt == bit_last) begin
                        rx_d.cnt      = '0;
                        stop_bad_n    = rx_q.stop_bad | ~line_s;
                        all_zero_n    = rx_q.all_zero & ~line_s;
                        rx_d.stop_bad = stop_bad_n;
                        rx_d.all_zero = all_zero_n;
                        if (rx_q.st == RX_STOP1 && rx_q.cfg.two_stop) rx_d.st = RX_STOP2;
                        else                                          do_finish = 1'b1;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (line_s) rx_d.st = RX_IDLE;
            end
            default: rx_d.st = RX_IDLE;
        endcase

        if (do_finish) begin
            rx_d.st = all_zero_n ? RX_HOLD : RX_IDLE;
            if (fifo_full) begin
                rx_d.ovr = 1'b1;
            end else begin
                rx_d.push = 1'b1;
                if (all_zero_n) begin
                    rx_d.dout = '0;
                    rx_d.fe   = 1'b0;
                    rx_d.pe   = 1'b0;
                    rx_d.be   = 1'b1;
                end else begin
                    rx_d.dout = rx_q.shreg;
                    rx_d.fe   = stop_bad_n;
                    rx_d.pe   = rx_q.cfg.par_en & par_err;
                    rx_d.be   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.st <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign push        = rx_q.push;
    assign push_data   = rx_q.dout;
    assign err_frame   = rx_q.fe;
    assign err_parity  = rx_q.pe;
    assign err_break   = rx_q.be;
    assign err_overrun = rx_q.ovr;
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              push,
    input logic [DATA_W-1:0] push_data,
    input logic              err_frame,
    input logic              err_parity,
    input logic              err_break,
    input logic              err_overrun
);
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R2

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !$past(fifo_full)); // R8

    AST_OVR_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(fifo_full)); // R8

    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && !fifo_full) |=> !err_overrun); // R8

    AST_BREAK_ZERO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (push && err_break) |-> (push_data == '0 && !err_frame && !err_parity)); // R6
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_full  (fifo_full),
    .push       (push),
    .push_data  (push_data),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_break  (err_break),
    .err_overrun(err_overrun)
);

// File: tb/uart_frame_rx_tb_top.sv
module uart_frame_rx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_ovs8 = 1'b1;
    logic [3:0] cfg_start_half = 4'd0;
    logic       fifo_full = 1'b0;
    logic       push;
    logic [7:0] push_data;
    logic       err_frame, err_parity, err_break, err_overrun;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // results of the last frame
    int         m_cyc;
    int         m_npush;
    logic [7:0] m_data;
    logic       m_fe, m_pe, m_be;
    logic [15:0] m_bits;
    int         m_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_en(rx_en), .rx_line(rx_line),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop), .cfg_ovs8(cfg_ovs8),
        .cfg_start_half(cfg_start_half), .fifo_full(fifo_full), .push(push),
        .push_data(push_data), .err_frame(err_frame), .err_parity(err_parity),
        .err_break(err_break), .err_overrun(err_overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one frame starting at a falling edge and watch for pushes
    task automatic frame(input logic [7:0] d, input int nb, input bit usep, input bit pbit,
                         input bit s1, input bit s2, input bit two, input int ovs,
                         input int hold_low);
        int k;
        k = 0;
        m_bits = '1;
        m_bits[k] = 1'b0; k++;
        for (int i = 0; i < nb; i++) begin m_bits[k] = d[i]; k++; end
        if (usep) begin m_bits[k] = pbit; k++; end
        m_bits[k] = s1; k++;
        if (two) begin m_bits[k] = s2; k++; end
        m_count = k;
        @(negedge clk);
        fork
            begin
                for (int i = 0; i < m_count; i++) begin
                    rx_line = m_bits[i];
                    repeat (ovs) @(negedge clk);
                end
                if (hold_low > 0) begin
                    rx_line = 1'b0;
                    repeat (hold_low) @(negedge clk);
                end
                rx_line = 1'b1;
            end
            begin
                m_cyc = -1;
                m_npush = 0;
                for (int c = 1; c <= m_count * ovs + hold_low + 20; c++) begin
                    @(posedge clk);
                    #1;
                    if (push) begin
                        m_npush++;
                        if (m_cyc < 0) begin
                            m_cyc  = c;
                            m_data = push_data;
                            m_fe   = err_frame;
                            m_pe   = err_parity;
                            m_be   = err_break;
                        end
                    end
                end
            end
        join
        repeat (4) @(negedge clk);
    endtask

    function automatic int due(input int half, input int ovs, input int k);
        return half + 4 + ovs * k;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] mask, pat, exp_d;
        bit pb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk(push == 1'b0, "R2 reset push", int'(push), 0);
        chk({err_frame, err_parity, err_break, err_overrun} == 4'b0, "R8 reset flags",
            int'({err_frame, err_parity, err_break, err_overrun}), 0);

        // R1 / R2: word lengths and patterns, no parity, one stop
        for (int wl = 0; wl < 4; wl++) begin
            cfg_wlen = 2'(wl);
            mask = 8'(('h1 << (5 + wl)) - 1);
            for (int v = 0; v < 16; v++) begin
                pat = 8'((v * 37 + 11) & 255);
                frame(pat, 5 + wl, 0, 0, 1, 1, 0, 8, 0);
                exp_d = pat & mask;
                chk(m_data == exp_d, "R1 data", int'(m_data), int'(exp_d));
                chk(m_cyc == due(3, 8, 6 + wl), "R2 push cycle", m_cyc, due(3, 8, 6 + wl));
                chk(m_npush == 1, "R2 single push", m_npush, 1);
                chk({m_fe, m_pe, m_be} == 3'b0, "R1 clean flags", int'({m_fe, m_pe, m_be}), 0);
            end
        end

        // R3 / R4: parity modes
        cfg_wlen = 2'd3;
        cfg_par_en = 1'b1;
        for (int st = 0; st < 2; st++) begin
            for (int ev = 0; ev < 2; ev++) begin
                for (int v = 0; v < 6; v++) begin
                    for (int bad = 0; bad < 2; bad++) begin
                        cfg_stick = st[0];
                        cfg_par_even = ev[0];
                        pat = 8'((v * 91 + 3) & 255);
                        if (st != 0) pb = (ev == 0);
                        else if (ev != 0) pb = ^pat;
                        else pb = ~^pat;
                        if (bad != 0) pb = ~pb;
                        frame(pat, 8, 1, pb, 1, 1, 0, 8, 0);
                        if (st != 0)
                            chk(m_pe == bad[0], "R4 stick parity", int'(m_pe), bad);
                        else
                            chk(m_pe == bad[0], "R3 parity", int'(m_pe), bad);
                        chk(m_cyc == due(3, 8, 10), "R3 parity frame cycle", m_cyc, due(3, 8, 10));
                    end
                end
            end
        end
        cfg_par_en = 1'b0;
        cfg_stick = 1'b0;

        // R5: frame errors, one and two stop bits
        frame(8'h55, 8, 0, 0, 0, 1, 0, 8, 0);
        chk(m_fe == 1'b1, "R5 stop low", int'(m_fe), 1);
        chk(m_data == 8'h55, "R5 data kept", int'(m_data), 'h55);
        cfg_two_stop = 1'b1;
        frame(8'h3C, 8, 0, 0, 1, 1, 1, 8, 0);
        chk(m_fe == 1'b0, "R5 two stops good", int'(m_fe), 0);
        chk(m_cyc == due(3, 8, 10), "R5 two stop cycle", m_cyc, due(3, 8, 10));
        frame(8'h3C, 8, 0, 0, 1, 0, 1, 8, 0);
        chk(m_fe == 1'b1, "R5 second stop low", int'(m_fe), 1);
        cfg_two_stop = 1'b0;

        // R6 / R7: break held past the frame, then normal character
        frame(8'h00, 8, 0, 0, 0, 0, 0, 8, 60);
        chk(m_npush == 1, "R6 one break push", m_npush, 1);
        chk(m_be == 1'b1 && m_data == 8'h00, "R6 break char", int'({m_be, m_data}), 'h100);
        chk(m_fe == 1'b0, "R6 no frame flag", int'(m_fe), 0);
        chk(m_cyc == due(3, 8, 9), "R6 break cycle", m_cyc, due(3, 8, 9));
        frame(8'hA7, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_npush == 1 && m_data == 8'hA7, "R7 rearmed", int'(m_data), 'hA7);
        chk(m_be == 1'b0, "R7 break flag cleared", int'(m_be), 0);

        // R8: overrun
        fifo_full = 1'b1;
        frame(8'h12, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_npush == 0, "R8 no push when full", m_npush, 0);
        chk(err_overrun == 1'b1, "R8 overrun set", int'(err_overrun), 1);
        chk(push_data == 8'hA7, "R8 previous char held", int'(push_data), 'hA7);
        fifo_full = 1'b0;
        @(posedge clk); #1;
        chk(err_overrun == 1'b0, "R8 overrun clears", int'(err_overrun), 0);

        // R9: 16 ticks per bit
        cfg_ovs8 = 1'b0;
        frame(8'hC3, 8, 0, 0, 1, 1, 0, 16, 0);
        chk(m_data == 8'hC3, "R9 ovs16 data", int'(m_data), 'hC3);
        chk(m_cyc == due(7, 16, 9), "R9 ovs16 cycle", m_cyc, due(7, 16, 9));
        cfg_ovs8 = 1'b1;

        // R10: programmed start half-period
        cfg_start_half = 4'd2;
        frame(8'h6B, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_data == 8'h6B, "R10 short start data", int'(m_data), 'h6B);
        chk(m_cyc == due(2, 8, 9), "R10 short start cycle", m_cyc, due(2, 8, 9));
        cfg_start_half = 4'd0;

        // R11: configuration change mid-character
        fork
            frame(8'hE9, 8, 0, 0, 1, 1, 0, 8, 0);
            begin
                repeat (20) @(negedge clk);
                cfg_wlen = 2'd0;
                cfg_par_en = 1'b1;
            end
        join
        chk(m_data == 8'hE9, "R11 latched length", int'(m_data), 'hE9);
        chk(m_cyc == due(3, 8, 9), "R11 latched cycle", m_cyc, due(3, 8, 9));
        cfg_wlen = 2'd3;
        cfg_par_en = 1'b0;

        // R12: glitch on the line
        @(negedge clk);
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        m_npush = 0;
        for (int c = 0; c < 120; c++) begin
            @(posedge clk); #1;
            if (push) m_npush++;
        end
        chk(m_npush == 0, "R12 glitch ignored", m_npush, 0);
        frame(8'h81, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_data == 8'h81 && m_cyc == due(3, 8, 9), "R12 recovers", m_cyc, due(3, 8, 9));

        // R13: receive disabled
        rx_en = 1'b0;
        frame(8'h44, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_npush == 0, "R13 disabled", m_npush, 0);
        rx_en = 1'b1;
        frame(8'h44, 8, 0, 0, 1, 1, 0, 8, 0);
        chk(m_npush == 1 && m_data == 8'h44, "R13 enabled again", int'(m_data), 'h44);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule